// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Unit

This unit holds the control state of a four-channel DMA controller: the command byte, the per-channel mask bits, the status byte and one mode byte per channel. A bus agent writes and reads it through eight byte-wide control offsets. Writes load the command, set or clear single mask bits, load the whole mask, store channel modes, post software requests, clear the byte-pointer flip-flop or perform a master clear. Reads return the status byte or the mask.

The status byte has two halves. The upper nibble holds one request flag per channel. Software request writes set these flags, and the external hold and release inputs set and clear them. The lower nibble holds one terminal-count flag per channel. The transfer engine sets these flags, and a status read clears them. The unit also drives the set of requests that are not masked, each channel's mode byte, the current command and a one-cycle pulse. The address and count side of the controller watches that pulse to clear its byte-pointer flip-flop.

Top module: `dma_ctrl_regs`

## Requirements
- R1: Asynchronous reset (rstN low) sets all four mask bits and clears the command, the status, every mode byte and ffClear.
- R2: A write to offset 0 loads wrData into the command only if no bit other than bit 2 is set. The value 0 is also loaded. Any other value is refused, and the command keeps its old value.
- R3: A write to offset 1 selects channel wrData[1:0]. If wrData[2] is 1 it sets that channel's request flag (status bit channel+4); otherwise it clears that flag. In both cases it clears the channel's terminal-count flag (status bit channel).
- R4: A write to offset 2 sets mask bit wrData[1:0] when wrData[2] is 1 and clears it when wrData[2] is 0. No other mask bit changes.
- R5: A write to offset 3 stores the whole byte as the mode of channel wrData[1:0]. That mode appears on chanMode[8*ch+7:8*ch], and the other channels' modes do not change.
- R6: A write to offset 4 drives ffClear high for exactly the one cycle after the write edge. Mask, command and status do not change.
- R7: A write to offset 5 pulses ffClear, sets all mask bits, and clears the status and the command. The mode bytes do not change.
- R8: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from wrData[3:0].
- R9: While rdEn is high, rdData shows the status byte for offset 0, {4'b0, mask} for offset 1, and 0 for any other offset. It is also 0 while rdEn is low. A read of offset 0 clears the terminal-count nibble at the clock edge.
- R10: holdReq[ch] sets and releaseReq[ch] clears the request flag of channel ch. A hold wins over a release in the same cycle.
- R11: tcHit[ch] sets the terminal-count flag of channel ch. It wins over a status-read clear in the same cycle.
- R12: reqVec is the request nibble ANDed with the inverse of the mask.
- R13: Writes to offsets 8 through 15 change no state and cause no ffClear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| portAddr | input | 4 | Control offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| holdReq | input | 4 | Per-channel hardware request set |
| releaseReq | input | 4 | Per-channel hardware request clear |
| tcHit | input | 4 | Per-channel terminal-count set from the engine |
| cmdOut | output | 8 | Current command byte |
| chanMask | output | 4 | Current mask, 1 = channel masked |
| reqVec | output | 4 | Pending requests that are not masked |
| chanMode | output | 32 | Mode bytes, channel n at bits [8n+7:8n] |
| ffClear | output | 1 | One-cycle byte-pointer flip-flop clear |

## Verification
Every stored bit of this unit reaches a port within one cycle. The mask and the command are always driven. A wrong request or terminal-count flag shows on the next offset-0 read, and a wrong request flag also shows on reqVec as soon as its mask bit is cleared. The bench therefore checks the outputs right after each write edge, and uses status reads to expose each flag change. Offset aliasing is caught by writes to offsets 8 through 15: a dropped address bit would turn those writes into a master clear or a mask load, and the change would show at once on chanMask or cmdOut.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  typedef enum logic [2:0] {
    OFS_CMD     = 3'd0,
    OFS_REQ     = 3'd1,
    OFS_MSK_ONE = 3'd2,
    OFS_MODE    = 3'd3,
    OFS_FFCLR   = 3'd4,
    OFS_MRST    = 3'd5,
    OFS_MSK_CLR = 3'd6,
    OFS_MSK_ALL = 3'd7
  } ctrlOfs_t;

  typedef struct packed {
    logic cmdLoad;
    logic reqWrite;
    logic maskSingle;
    logic modeWrite;
    logic ffClr;
    logic masterRst;
    logic maskClrAll;
    logic maskLoad;
    logic statusRead;
    logic maskRead;
  } ctrlStrobes_t;
endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_ALLOWED = 8'h04
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [PORT_W-1:0] portAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strb
);
  localparam int OFS_W = 3;

  logic     inRange;
  ctrlOfs_t ofs;
  logic     cmdOk;

  assign inRange = (portAddr[PORT_W-1:OFS_W] == '0);
  assign ofs     = ctrlOfs_t'(portAddr[OFS_W-1:0]);
  // Zero has no unsupported bits, so it always passes.
  assign cmdOk   = ((wrData & ~CMD_ALLOWED) == '0);

  always_comb begin
    strb = '0;
    if (wrEn && inRange) begin
      unique case (ofs)
        OFS_CMD:     strb.cmdLoad    = cmdOk;
        OFS_REQ:     strb.reqWrite   = 1'b1;
        OFS_MSK_ONE: strb.maskSingle = 1'b1;
        OFS_MODE:    strb.modeWrite  = 1'b1;
        OFS_FFCLR:   strb.ffClr      = 1'b1;
        OFS_MRST: begin
          strb.ffClr     = 1'b1;
          strb.masterRst = 1'b1;
        end
        OFS_MSK_CLR: strb.maskClrAll = 1'b1;
        OFS_MSK_ALL: strb.maskLoad   = 1'b1;
        default: ;
      endcase
    end
    if (rdEn && inRange) begin
      strb.statusRead = (ofs == OFS_CMD);
      strb.maskRead   = (ofs == OFS_REQ);
    end
  end
endmodule

// File: rtl/dma_ctrl_store.sv
module dma_ctrl_store
  import dma_ctrl_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [CHAN_CNT-1:0]        holdReq,
  input  logic [CHAN_CNT-1:0]        releaseReq,
  input  logic [CHAN_CNT-1:0]        tcHit,
  output logic [DATA_W-1:0]          rdData,
  output logic [DATA_W-1:0]          cmdOut,
  output logic [CHAN_CNT-1:0]        chanMask,
  output logic [CHAN_CNT-1:0]        reqVec,
  output logic [CHAN_CNT*DATA_W-1:0] chanMode,
  output logic                       ffClear
);
  localparam int CHAN_W = $clog2(CHAN_CNT);

  logic [DATA_W-1:0]   cmdQ;
  logic [CHAN_CNT-1:0] maskQ, maskNext;
  logic [CHAN_CNT-1:0] reqQ, reqNext;
  logic [CHAN_CNT-1:0] tcQ, tcNext;
  logic [DATA_W-1:0]   modeQ [CHAN_CNT];
  logic                ffQ;
  logic [CHAN_W-1:0]   chanSel;
  logic                setBit;
  logic [CHAN_CNT-1:0] chanHot;

  assign chanSel = wrData[CHAN_W-1:0];
  assign setBit  = wrData[CHAN_W];
  assign chanHot = CHAN_CNT'(1) << chanSel;

  always_comb begin
    maskNext = maskQ;
    if (strb.maskSingle) maskNext = setBit ? (maskQ | chanHot) : (maskQ & ~chanHot);
    if (strb.maskClrAll) maskNext = '0;
    if (strb.maskLoad)   maskNext = wrData[CHAN_CNT-1:0];
    if (strb.masterRst)  maskNext = '1;

    reqNext = reqQ;
    if (strb.reqWrite) reqNext = setBit ? (reqQ | chanHot) : (reqQ & ~chanHot);
    reqNext = (reqNext & ~releaseReq) | holdReq;

    tcNext = tcQ;
    if (strb.statusRead) tcNext = '0;
    if (strb.reqWrite)   tcNext = tcNext & ~chanHot;
    tcNext = tcNext | tcHit;

    if (strb.masterRst) begin
      reqNext = '0;
      tcNext  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      maskQ <= '1;
      reqQ  <= '0;
      tcQ   <= '0;
      ffQ   <= 1'b0;
    end else begin
      if (strb.masterRst)    cmdQ <= '0;
      else if (strb.cmdLoad) cmdQ <= wrData;
      maskQ <= maskNext;
      reqQ  <= reqNext;
      tcQ   <= tcNext;
      ffQ   <= strb.ffClr;
    end
  end

  for (genvar c = 0; c < CHAN_CNT; c++) begin : g_mode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modeQ[c] <= '0;
      else if (strb.modeWrite && chanSel == CHAN_W'(c)) modeQ[c] <= wrData;
    end
    assign chanMode[c*DATA_W +: DATA_W] = modeQ[c];
  end

  always_comb begin
    rdData = '0;
    if (strb.statusRead)    rdData = DATA_W'({reqQ, tcQ});
    else if (strb.maskRead) rdData = DATA_W'(maskQ);
  end

  assign cmdOut   = cmdQ;
  assign chanMask = maskQ;
  assign reqVec   = reqQ & ~maskQ;
  assign ffClear  = ffQ;

  // R7: master clear leaves every channel masked
  p_mrst_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.masterRst |=> (&chanMask));

  // R6: the clear pulse follows its strobe and lasts one cycle
  p_ff_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ffClr |=> ffClear);
  p_ff_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ffClr |=> !ffClear);

  // R9: a status read with no new terminal count empties the low nibble
  p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRead && tcHit == '0) |=> (tcQ == '0));

  // R10: a hold is visible in the request flags on the next cycle
  p_hold_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq != '0 && !strb.masterRst) |=> ((reqQ & $past(holdReq)) == $past(holdReq)));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = 4,
  parameter logic [DATA_W-1:0] CMD_ALLOWED = 8'h04
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [PORT_W-1:0]          portAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [CHAN_CNT-1:0]        holdReq,
  input  logic [CHAN_CNT-1:0]        releaseReq,
  input  logic [CHAN_CNT-1:0]        tcHit,
  output logic [DATA_W-1:0]          cmdOut,
  output logic [CHAN_CNT-1:0]        chanMask,
  output logic [CHAN_CNT-1:0]        reqVec,
  output logic [CHAN_CNT*DATA_W-1:0] chanMode,
  output logic                       ffClear
);
  ctrlStrobes_t strb;

  dma_ctrl_decode #(
    .PORT_W(PORT_W), .DATA_W(DATA_W), .CMD_ALLOWED(CMD_ALLOWED)
  ) u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .portAddr(portAddr), .wrData(wrData), .strb(strb)
  );

  dma_ctrl_store #(
    .CHAN_CNT(CHAN_CNT), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .holdReq(holdReq), .releaseReq(releaseReq), .tcHit(tcHit),
    .rdData(rdData), .cmdOut(cmdOut), .chanMask(chanMask),
    .reqVec(reqVec), .chanMode(chanMode), .ffClear(ffClear)
  );

  // R2: a command with unsupported bits leaves the command unchanged
  p_cmd_refuse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == '0 && (wrData & ~CMD_ALLOWED) != '0) |=> $stable(cmdOut));

  // R13: offsets 8..15 touch nothing visible
  p_high_ofs_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr[PORT_W-1] && holdReq == '0 && releaseReq == '0 && tcHit == '0)
    |=> ($stable(chanMask) && $stable(cmdOut) && $stable(chanMode) && !ffClear));
endmodule

// File: tb/sim_dma_ctrl_regs.sv
module sim_dma_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  portAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  holdReq = '0, releaseReq = '0, tcHit = '0;
  logic [7:0]  cmdOut;
  logic [3:0]  chanMask, reqVec;
  logic [31:0] chanMode;
  logic        ffClear;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dma_ctrl_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portAddr(portAddr),
    .wrData(wrData), .rdData(rdData), .holdReq(holdReq), .releaseReq(releaseReq),
    .tcHit(tcHit), .cmdOut(cmdOut), .chanMask(chanMask), .reqVec(reqVec),
    .chanMode(chanMode), .ffClear(ffClear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {wr, rd, addr[3:0], data[7:0], expMask[3:0], expCmd[7:0], expRd[7:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1,1'b0,4'h0,8'h04,4'hF,8'h04,8'h00}, // R2 allowed bit 2
    {1'b1,1'b0,4'h0,8'h01,4'hF,8'h04,8'h00}, // R2 refused
    {1'b1,1'b0,4'h0,8'h00,4'hF,8'h00,8'h00}, // R2 zero loads
    {1'b1,1'b0,4'h0,8'h04,4'hF,8'h04,8'h00}, // R2
    {1'b1,1'b0,4'h0,8'h80,4'hF,8'h04,8'h00}, // R2 refused
    {1'b1,1'b0,4'h0,8'h08,4'hF,8'h04,8'h00}, // R2 refused
    {1'b1,1'b0,4'h2,8'h01,4'hD,8'h04,8'h00}, // R4 clear bit 1
    {1'b1,1'b0,4'h2,8'h02,4'h9,8'h04,8'h00}, // R4 clear bit 2
    {1'b1,1'b0,4'h2,8'h05,4'hB,8'h04,8'h00}, // R4 set bit 1
    {1'b1,1'b0,4'h6,8'h00,4'h0,8'h04,8'h00}, // R8 clear all
    {1'b1,1'b0,4'h2,8'h06,4'h4,8'h04,8'h00}, // R4 set bit 2
    {1'b1,1'b0,4'h7,8'h0A,4'hA,8'h04,8'h00}, // R8 load
    {1'b0,1'b1,4'h1,8'h00,4'hA,8'h04,8'h0A}, // R9 mask read
    {1'b0,1'b1,4'h2,8'h00,4'hA,8'h04,8'h00}, // R9 other offset
    {1'b1,1'b0,4'h8,8'hFF,4'hA,8'h04,8'h00}, // R13
    {1'b1,1'b0,4'hD,8'h00,4'hA,8'h04,8'h00}, // R13
    {1'b1,1'b0,4'hF,8'h00,4'hA,8'h04,8'h00}, // R13
    {1'b1,1'b0,4'h1,8'h05,4'hA,8'h04,8'h00}, // R3 set ch1
    {1'b0,1'b1,4'h0,8'h00,4'hA,8'h04,8'h20}, // R9 status
    {1'b1,1'b0,4'h1,8'h01,4'hA,8'h04,8'h00}, // R3 clear ch1
    {1'b0,1'b1,4'h0,8'h00,4'hA,8'h04,8'h00}, // R9 status
    {1'b1,1'b0,4'h1,8'h07,4'hA,8'h04,8'h00}, // R3 set ch3
    {1'b0,1'b1,4'h0,8'h00,4'hA,8'h04,8'h80}, // R9 status
    {1'b0,1'b1,4'h1,8'h00,4'hA,8'h04,8'h0A}  // R9 mask read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic wr, input logic [3:0] a);
    if (!wr) return "R9";
    if (a[3]) return "R13";
    case (a[2:0])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic wrOp(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; portAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdOp(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; portAddr = a;
    #(CLK_PERIOD/4) chk(tag, 32'(rdData), 32'(exp));
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic sideOp(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t);
    @(negedge clk);
    holdReq = h; releaseReq = r; tcHit = t;
    @(posedge clk); #1;
    holdReq = '0; releaseReq = '0; tcHit = '0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual hung expected done");
      finishRun();
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    // R1: state held in reset
    chk("R1 mask", 32'(chanMask), 32'hF);
    chk("R1 cmd", 32'(cmdOut), 32'h0);
    chk("R1 mode", chanMode, 32'h0);
    chk("R1 ffClear", 32'(ffClear), 32'h0);
    @(negedge clk) rstN = 1'b1;
    rdOp(4'h0, 8'h00, "R1 status");
    chk("R1 reqVec", 32'(reqVec), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = VEC[i][33]; rdEn = VEC[i][32];
      portAddr = VEC[i][31:28]; wrData = VEC[i][27:20];
      #(CLK_PERIOD/4);
      if (VEC[i][32]) chk($sformatf("%s step %0d rdData", tagOf(VEC[i][33], VEC[i][31:28]), i),
                          32'(rdData), 32'(VEC[i][7:0]));
      @(posedge clk); #1;
      wrEn = 1'b0; rdEn = 1'b0;
      chk($sformatf("%s step %0d mask", tagOf(VEC[i][33], VEC[i][31:28]), i),
          32'(chanMask), 32'(VEC[i][19:16]));
      chk($sformatf("%s step %0d cmd", tagOf(VEC[i][33], VEC[i][31:28]), i),
          32'(cmdOut), 32'(VEC[i][15:8]));
      if (VEC[i][33] && VEC[i][31])
        chk($sformatf("R13 step %0d ffClear", i), 32'(ffClear), 32'h0);
    end

    // state now: mask A, cmd 04, req 1000, tc 0
    chk("R12 reqVec masked", 32'(reqVec), 32'h0);
    wrOp(4'h2, 8'h03);
    chk("R12 reqVec unmasked", 32'(reqVec), 32'h8);

    // R10 hold and release
    sideOp(4'h1, 4'h0, 4'h0);
    chk("R10 hold ch0", 32'(reqVec), 32'h9);
    sideOp(4'h0, 4'h8, 4'h0);
    chk("R10 release ch3", 32'(reqVec), 32'h1);
    sideOp(4'h4, 4'h4, 4'h0);
    chk("R10 hold wins", 32'(reqVec), 32'h5);
    rdOp(4'h0, 8'h50, "R10 status");

    // R11 terminal count, R9 clear on read
    sideOp(4'h0, 4'h0, 4'h5);
    rdOp(4'h0, 8'h55, "R11 tc set");
    rdOp(4'h0, 8'h50, "R9 tc cleared");
    @(negedge clk);
    rdEn = 1'b1; portAddr = 4'h0; tcHit = 4'h2;
    #(CLK_PERIOD/4) chk("R11 read with tcHit", 32'(rdData), 32'h50);
    @(posedge clk); #1;
    rdEn = 1'b0; tcHit = '0;
    rdOp(4'h0, 8'h52, "R11 tcHit beats clear");
    rdOp(4'h0, 8'h50, "R9 tc cleared again");

    // R3 request write clears the channel's terminal count
    sideOp(4'h0, 4'h0, 4'h8);
    wrOp(4'h1, 8'h03);
    rdOp(4'h0, 8'h50, "R3 tc3 cleared");

    // R5 modes
    wrOp(4'h3, 8'h56);
    chk("R5 mode ch2", chanMode, 32'h0056_0000);
    wrOp(4'h3, 8'hA9);
    chk("R5 mode ch1", chanMode, 32'h0056_A900);
    wrOp(4'h3, 8'h57);
    chk("R5 mode ch3", chanMode, 32'h5756_A900);

    // R6 flip-flop clear pulse
    chk("R6 idle", 32'(ffClear), 32'h0);
    wrOp(4'h4, 8'h00);
    chk("R6 pulse", 32'(ffClear), 32'h1);
    chk("R6 mask kept", 32'(chanMask), 32'h2);
    idle();
    chk("R6 pulse ends", 32'(ffClear), 32'h0);
    rdOp(4'h0, 8'h50, "R6 status kept");

    // R7 master clear
    wrOp(4'h5, 8'h00);
    chk("R7 ffClear", 32'(ffClear), 32'h1);
    chk("R7 mask", 32'(chanMask), 32'hF);
    chk("R7 cmd", 32'(cmdOut), 32'h0);
    chk("R7 modes kept", chanMode, 32'h5756_A900);
    rdOp(4'h0, 8'h00, "R7 status");

    // R1 asynchronous reset mid-run
    wrOp(4'h6, 8'h00);
    chk("R8 clear all", 32'(chanMask), 32'h0);
    #2 rstN = 1'b0;
    #1;
    chk("R1 async mask", 32'(chanMask), 32'hF);
    chk("R1 async mode", chanMode, 32'h0);
    @(negedge clk) rstN = 1'b1;

    done = 1'b1;
    finishRun();
  end
endmodule